// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Unit

This block gathers the event sources of an SD card host controller into two 32-bit status words and raises one interrupt line from them. The first word carries command and data completion and card insertion or removal. The second word carries the per-command error flags and the buffer-ready notifications. Alongside the latched events, each word also shows a few live line levels: the synchronised card-detect level, the level of data line 0 and the command-busy state.

Software reads the words through a small register port and acknowledges an event by writing a 0 to its bit. A 1 written to a bit leaves that bit unchanged. Each status word has its own mask word, where a 1 silences the matching source. The card-detect pin is asynchronous. It passes through a flop synchroniser, and its synchronised edges produce the insert and remove events. The buffer-ready sources are levels, but they are reported as events: only a rising level sets their bit, so a bit that software has acknowledged stays clear while the buffer remains ready.

Top module: `sdhost_irq_status`

## Requirements
- R1: After reset every latched status bit reads 0, both mask words read all ones and `irq` is 0.
- R2: A one-cycle pulse on `evt_cmd_resp` sets status A bit 0, and one on `evt_data_done` sets status A bit 2. A pulse on `err_evt[k]` sets status B bit k for k = 0..6, and a pulse on `err_evt[7]` sets status B bit 15. Each set bit holds until software clears it.
- R3: A write to a status word clears every latched bit whose write-data bit is 0 and leaves every bit whose write-data bit is 1 unchanged.
- R4: When a set event and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R5: Status B bit 8 (read ready) is set only on a rising edge of `rd_buf_ready`, and bit 9 (write ready) only on a rising edge of `wr_buf_ready`. After either bit is cleared it stays 0 while its level stays high, and it is set again on the next rising edge.
- R6: Status A bit 5 shows the synchronised card-detect level, status B bit 7 shows `dat0_level` and status B bit 14 shows `cmd_busy`. Writes have no effect on these three bits.
- R7: `cd_pin` passes through a two-flop synchroniser. A change on the pin shows in status A bit 5 after two clock edges. The matching event appears after three edges: status A bit 4 (inserted) on a rising level, or status A bit 3 (removed) on a falling level.
- R8: `irq` is 1 exactly when some latched status bit is 1 and its mask bit is 0. A mask bit of 1 blocks that bit, and live-level bits never drive `irq`.
- R9: `reg_sel` picks the word for a read or write: 0 selects status A, 1 selects status B, 2 selects mask A and 3 selects mask B. The mask words read back the full value last written to them.
- R10: Status bit positions that carry no source always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Word select: 0 status A, 1 status B, 2 mask A, 3 mask B |
| wr_en | input | 1 | Write strobe for the selected word |
| wdata | input | 32 | Write data (0 clears a status bit) |
| rdata | output | 32 | Read data of the selected word |
| evt_cmd_resp | input | 1 | Pulse: command response received |
| evt_data_done | input | 1 | Pulse: data transfer finished |
| err_evt | input | 8 | Error pulses: [0] index, [1] CRC, [2] end bit, [3] timeout, [4] illegal write, [5] illegal read, [6] response timeout, [7] illegal access |
| rd_buf_ready | input | 1 | Level: read buffer holds a block |
| wr_buf_ready | input | 1 | Level: write buffer can accept a block |
| cmd_busy | input | 1 | Level: command line busy |
| dat0_level | input | 1 | Level of data line 0 |
| cd_pin | input | 1 | Asynchronous card-detect pin, 1 = card present |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that the event inputs are single-cycle pulses that are synchronous to `clk`, and that `rd_buf_ready` stays low while reset is asserted. The property on the buffer-ready hold also excludes the first cycle after reset. The bench changes every input, including the asynchronous `cd_pin`, only at falling clock edges. It raises each pulse for exactly one cycle and keeps every level input low during reset. Because of this, the synchroniser latency is a fixed two edges and the event latency a fixed three edges, which the bench counts directly.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;

   typedef enum logic [1:0] {
      SEL_STAT_A = 2'd0,
      SEL_STAT_B = 2'd1,
      SEL_MASK_A = 2'd2,
      SEL_MASK_B = 2'd3
   } sdirq_sel_e;

   // status word A bit positions
   localparam int unsigned A_RESP    = 0;
   localparam int unsigned A_DATA    = 2;
   localparam int unsigned A_REMOVE  = 3;
   localparam int unsigned A_INSERT  = 4;
   localparam int unsigned A_CD_LVL  = 5;

   // status word B bit positions
   localparam int unsigned B_DAT0    = 7;
   localparam int unsigned B_RDY_RD  = 8;
   localparam int unsigned B_RDY_WR  = 9;
   localparam int unsigned B_BUSY    = 14;
   localparam int unsigned B_ILL_ACC = 15;

   localparam int unsigned ERR_N     = 8;
   localparam int unsigned MIN_W     = 16;

   // error input k -> status B bit position
   function automatic int unsigned err_pos(input int unsigned k);
      return (k < 7) ? k : B_ILL_ACC;
   endfunction

endpackage

// File: rtl/sdirq_cd_sync.sv
module sdirq_cd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic rise,
   output logic fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sdirq_cd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level = chain_q[STAGES-1];
   assign rise  = level & ~prev_q;
   assign fall  = ~level & prev_q;

endmodule

// File: rtl/sdirq_rise_bank.sv
module sdirq_rise_bank #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise
);

   if (N < 1) begin : g_bad_n
      $error("sdirq_rise_bank: N must be at least 1");
   end

   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   for (genvar i = 0; i < N; i++) begin : g_edge
      assign rise[i] = lvl[i] & ~prev_q[i];
   end

endmodule

// File: rtl/sdirq_stat_reg.sv
module sdirq_stat_reg #(
   parameter int unsigned       W          = 32,
   parameter logic [W-1:0]      LATCH_MASK = '0,
   parameter logic [W-1:0]      LIVE_MASK  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] live_vec,
   output logic [W-1:0] value,
   output logic [W-1:0] latched
);

   if ((LATCH_MASK & LIVE_MASK) != '0) begin : g_bad_overlap
      $error("sdirq_stat_reg: a bit cannot be both latched and live");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (LATCH_MASK[i]) begin : g_latch
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   bit_q <= 1'b0;
            else if (set_vec[i])          bit_q <= 1'b1;
            else if (wr_en && !wdata[i])  bit_q <= 1'b0;
         end
         assign value[i]   = bit_q;
         assign latched[i] = bit_q;
      end else if (LIVE_MASK[i]) begin : g_live
         assign value[i]   = live_vec[i];
         assign latched[i] = 1'b0;
      end else begin : g_empty
         assign value[i]   = 1'b0;
         assign latched[i] = 1'b0;
      end
   end

   logic unused_inputs;
   assign unused_inputs = ^{set_vec & ~LATCH_MASK, live_vec & ~LIVE_MASK,
                            wdata & ~LATCH_MASK};

endmodule

// File: rtl/sdhost_irq_status.sv
module sdhost_irq_status
   import sdirq_pkg::*;
#(
   parameter int unsigned        DATA_W         = 32,
   parameter int unsigned        CD_SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0]  MASK_RST       = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           reg_sel,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   input  logic                 evt_cmd_resp,
   input  logic                 evt_data_done,
   input  logic [ERR_N-1:0]     err_evt,
   input  logic                 rd_buf_ready,
   input  logic                 wr_buf_ready,
   input  logic                 cmd_busy,
   input  logic                 dat0_level,
   input  logic                 cd_pin,
   output logic                 irq
);

   if (DATA_W < MIN_W) begin : g_bad_width
      $error("sdhost_irq_status: DATA_W must be at least 16");
   end

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   localparam logic [DATA_W-1:0] LATCH_A = (ONE << A_RESP) | (ONE << A_DATA) |
                                           (ONE << A_REMOVE) | (ONE << A_INSERT);
   localparam logic [DATA_W-1:0] LIVE_A  = (ONE << A_CD_LVL);
   localparam logic [DATA_W-1:0] LATCH_B = DATA_W'(7'h7F) | (ONE << B_RDY_RD) |
                                           (ONE << B_RDY_WR) | (ONE << B_ILL_ACC);
   localparam logic [DATA_W-1:0] LIVE_B  = (ONE << B_DAT0) | (ONE << B_BUSY);

   // card detect synchroniser and edge events
   logic cd_level, cd_rise, cd_fall;

   sdirq_cd_sync #(.STAGES(CD_SYNC_STAGES)) cd_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (cd_pin),
      .level (cd_level),
      .rise  (cd_rise),
      .fall  (cd_fall)
   );

   // buffer-ready rising edges: [0] read, [1] write
   logic [1:0] rdy_rise;

   sdirq_rise_bank #(.N(2)) rdy_edge_i (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   ({wr_buf_ready, rd_buf_ready}),
      .rise  (rdy_rise)
   );

   // set and live vectors
   logic [DATA_W-1:0] set_a, set_b, live_a, live_b;

   always_comb begin
      set_a            = '0;
      set_a[A_RESP]    = evt_cmd_resp;
      set_a[A_DATA]    = evt_data_done;
      set_a[A_REMOVE]  = cd_fall;
      set_a[A_INSERT]  = cd_rise;

      live_a           = '0;
      live_a[A_CD_LVL] = cd_level;

      set_b            = '0;
      for (int unsigned k = 0; k < ERR_N; k++) begin
         set_b[err_pos(k)] = err_evt[k];
      end
      set_b[B_RDY_RD]  = rdy_rise[0];
      set_b[B_RDY_WR]  = rdy_rise[1];

      live_b           = '0;
      live_b[B_DAT0]   = dat0_level;
      live_b[B_BUSY]   = cmd_busy;
   end

   // write decode
   logic wr_stat_a, wr_stat_b, wr_mask_a, wr_mask_b;

   assign wr_stat_a = wr_en && (reg_sel == SEL_STAT_A);
   assign wr_stat_b = wr_en && (reg_sel == SEL_STAT_B);
   assign wr_mask_a = wr_en && (reg_sel == SEL_MASK_A);
   assign wr_mask_b = wr_en && (reg_sel == SEL_MASK_B);

   // status words
   logic [DATA_W-1:0] stat_a_val, stat_b_val, lat_a, lat_b;

   sdirq_stat_reg #(.W(DATA_W), .LATCH_MASK(LATCH_A), .LIVE_MASK(LIVE_A)) stat_a_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_stat_a),
      .wdata    (wdata),
      .set_vec  (set_a),
      .live_vec (live_a),
      .value    (stat_a_val),
      .latched  (lat_a)
   );

   sdirq_stat_reg #(.W(DATA_W), .LATCH_MASK(LATCH_B), .LIVE_MASK(LIVE_B)) stat_b_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_stat_b),
      .wdata    (wdata),
      .set_vec  (set_b),
      .live_vec (live_b),
      .value    (stat_b_val),
      .latched  (lat_b)
   );

   // mask words
   logic [DATA_W-1:0] mask_a_q, mask_b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_a_q <= MASK_RST;
         mask_b_q <= MASK_RST;
      end else begin
         if (wr_mask_a) mask_a_q <= wdata;
         if (wr_mask_b) mask_b_q <= wdata;
      end
   end

   // interrupt combine
   assign irq = (|(lat_a & ~mask_a_q)) | (|(lat_b & ~mask_b_q));

   // read mux
   always_comb begin
      unique case (reg_sel)
         SEL_STAT_A: rdata = stat_a_val;
         SEL_STAT_B: rdata = stat_b_val;
         SEL_MASK_A: rdata = mask_a_q;
         default:    rdata = mask_b_q;
      endcase
   end

endmodule

// File: rtl/sdirq_chk.sv
module sdirq_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        reg_sel,
   input logic              wr_en,
   input logic [DATA_W-1:0] wdata,
   input logic              evt_cmd_resp,
   input logic              rd_buf_ready,
   input logic [DATA_W-1:0] stat_a,
   input logic [DATA_W-1:0] stat_b,
   input logic [DATA_W-1:0] mask_a,
   input logic [DATA_W-1:0] mask_b,
   input logic              irq
);

   logic clr_a0;
   assign clr_a0 = wr_en && (reg_sel == 2'd0) && !wdata[0];

   // R3
   clear_a0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_a0 && !evt_cmd_resp) |=> !stat_a[0]);

   // R4
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_cmd_resp |=> stat_a[0]);

   // R2
   hold_a0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_a[0] && !clr_a0) |=> stat_a[0]);

   // R8
   all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_a && &mask_b) |-> !irq);

   // R8
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|((stat_a & ~mask_a) | (stat_b & ~mask_b))));

   // R5
   rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_b[8]) |-> $past(rd_buf_ready));

   // R5
   rdy_stay_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && rd_buf_ready && $past(rd_buf_ready) && !stat_b[8])
      |=> !stat_b[8]);

   // R7
   insert_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_a[4]) |-> $past(stat_a[5]));

endmodule

bind sdhost_irq_status sdirq_chk #(.DATA_W(DATA_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_sel      (reg_sel),
   .wr_en        (wr_en),
   .wdata        (wdata),
   .evt_cmd_resp (evt_cmd_resp),
   .rd_buf_ready (rd_buf_ready),
   .stat_a       (stat_a_val),
   .stat_b       (stat_b_val),
   .mask_a       (mask_a_q),
   .mask_b       (mask_b_q),
   .irq          (irq)
);

// File: tb/sdhost_irq_status_tb_top.sv
module sdhost_irq_status_tb_top;

   localparam int W          = 32;
   localparam int WD_CYCLES  = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    reg_sel = 2'd0;
   logic          wr_en = 1'b0;
   logic [W-1:0]  wdata = '0;
   logic [W-1:0]  rdata;
   logic          evt_cmd_resp = 1'b0;
   logic          evt_data_done = 1'b0;
   logic [7:0]    err_evt = '0;
   logic          rd_buf_ready = 1'b0;
   logic          wr_buf_ready = 1'b0;
   logic          cmd_busy = 1'b0;
   logic          dat0_level = 1'b0;
   logic          cd_pin = 1'b0;
   logic          irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   sdhost_irq_status dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .reg_sel       (reg_sel),
      .wr_en         (wr_en),
      .wdata         (wdata),
      .rdata         (rdata),
      .evt_cmd_resp  (evt_cmd_resp),
      .evt_data_done (evt_data_done),
      .err_evt       (err_evt),
      .rd_buf_ready  (rd_buf_ready),
      .wr_buf_ready  (wr_buf_ready),
      .cmd_busy      (cmd_busy),
      .dat0_level    (dat0_level),
      .cd_pin        (cd_pin),
      .irq           (irq)
   );

   task automatic check(input string req, input string what,
                        input logic [W-1:0] got, input logic [W-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   task automatic check_reg(input string req, input logic [1:0] sel,
                            input logic [W-1:0] exp);
      reg_sel = sel;
      #1;
      check(req, $sformatf("word %0d", sel), rdata, exp);
   endtask

   task automatic check_irq(input string req, input logic exp);
      #1;
      check(req, "irq", {31'd0, irq}, {31'd0, exp});
   endtask

   task automatic write_reg(input logic [1:0] sel, input logic [W-1:0] d);
      @(negedge clk);
      reg_sel = sel;
      wdata   = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic pulse(input logic resp, input logic dat, input logic [7:0] err);
      @(negedge clk);
      evt_cmd_resp  = resp;
      evt_data_done = dat;
      err_evt       = err;
      @(negedge clk);
      evt_cmd_resp  = 1'b0;
      evt_data_done = 1'b0;
      err_evt       = '0;
   endtask

   task automatic clear_all();
      write_reg(2'd0, '0);
      write_reg(2'd1, '0);
   endtask

   // R1 R9
   task automatic t_reset();
      check_reg("R1", 2'd0, 32'h0);
      check_reg("R1", 2'd1, 32'h0);
      check_reg("R1", 2'd2, 32'hFFFF_FFFF);
      check_reg("R1", 2'd3, 32'hFFFF_FFFF);
      check_irq("R1", 1'b0);
   endtask

   // R2 R10
   task automatic t_events();
      pulse(1'b1, 1'b1, 8'hFF);
      check_reg("R2", 2'd0, 32'h0000_0005);
      check_reg("R2", 2'd1, 32'h0000_807F);
      check_irq("R8", 1'b0);
      write_reg(2'd0, 32'hFFFF_FFFF);
      check_reg("R10", 2'd0, 32'h0000_0005);
   endtask

   // R3
   task automatic t_clear();
      write_reg(2'd0, 32'hFFFF_FFFE);
      check_reg("R3", 2'd0, 32'h0000_0004);
      write_reg(2'd1, 32'hFFFF_7FFF);
      check_reg("R3", 2'd1, 32'h0000_007F);
      clear_all();
      check_reg("R3", 2'd0, 32'h0);
      check_reg("R3", 2'd1, 32'h0);
   endtask

   // R8 R9 R6
   task automatic t_irq();
      write_reg(2'd2, 32'hFFFF_FFFB);
      check_reg("R9", 2'd2, 32'hFFFF_FFFB);
      check_irq("R8", 1'b0);
      pulse(1'b1, 1'b0, 8'h00);
      check_irq("R8", 1'b0);
      pulse(1'b0, 1'b1, 8'h00);
      check_irq("R8", 1'b1);
      write_reg(2'd0, 32'hFFFF_FFFB);
      check_irq("R8", 1'b0);
      write_reg(2'd3, 32'h0);
      check_reg("R9", 2'd3, 32'h0);
      @(negedge clk);
      dat0_level = 1'b1;
      cmd_busy   = 1'b1;
      check_reg("R6", 2'd1, 32'h0000_4080);
      check_irq("R8", 1'b0);
      write_reg(2'd1, 32'h0);
      check_reg("R6", 2'd1, 32'h0000_4080);
      pulse(1'b0, 1'b0, 8'h80);
      check_reg("R2", 2'd1, 32'h0000_C080);
      check_irq("R8", 1'b1);
      write_reg(2'd1, 32'h0);
      check_irq("R8", 1'b0);
      @(negedge clk);
      dat0_level = 1'b0;
      cmd_busy   = 1'b0;
      write_reg(2'd2, 32'hFFFF_FFFF);
      write_reg(2'd3, 32'hFFFF_FFFF);
      clear_all();
   endtask

   // R4
   task automatic t_set_wins();
      pulse(1'b0, 1'b1, 8'h00);
      @(negedge clk);
      evt_cmd_resp = 1'b1;
      reg_sel      = 2'd0;
      wdata        = '0;
      wr_en        = 1'b1;
      @(negedge clk);
      evt_cmd_resp = 1'b0;
      wr_en        = 1'b0;
      check_reg("R4", 2'd0, 32'h0000_0001);
      clear_all();
   endtask

   // R5
   task automatic t_buf_ready();
      @(negedge clk);
      rd_buf_ready = 1'b1;
      @(negedge clk);
      check_reg("R5", 2'd1, 32'h0000_0100);
      write_reg(2'd1, 32'h0);
      check_reg("R5", 2'd1, 32'h0);
      repeat (3) @(negedge clk);
      check_reg("R5", 2'd1, 32'h0);
      rd_buf_ready = 1'b0;
      @(negedge clk);
      rd_buf_ready = 1'b1;
      @(negedge clk);
      check_reg("R5", 2'd1, 32'h0000_0100);
      wr_buf_ready = 1'b1;
      @(negedge clk);
      check_reg("R5", 2'd1, 32'h0000_0300);
      write_reg(2'd1, 32'hFFFF_FEFF);
      check_reg("R5", 2'd1, 32'h0000_0200);
      rd_buf_ready = 1'b0;
      wr_buf_ready = 1'b0;
      clear_all();
   endtask

   // R7 R6
   task automatic t_card_detect();
      @(negedge clk);
      cd_pin = 1'b1;
      @(negedge clk);
      check_reg("R7", 2'd0, 32'h0);
      @(negedge clk);
      check_reg("R7", 2'd0, 32'h0000_0020);
      @(negedge clk);
      check_reg("R7", 2'd0, 32'h0000_0030);
      check_irq("R8", 1'b0);
      write_reg(2'd0, 32'h0);
      check_reg("R6", 2'd0, 32'h0000_0020);
      @(negedge clk);
      cd_pin = 1'b0;
      @(negedge clk);
      check_reg("R7", 2'd0, 32'h0000_0020);
      @(negedge clk);
      check_reg("R7", 2'd0, 32'h0);
      @(negedge clk);
      check_reg("R7", 2'd0, 32'h0000_0008);
      clear_all();
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_events();
      t_clear();
      t_irq();
      t_set_wins();
      t_buf_ready();
      t_card_detect();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(WD_CYCLES * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule